// File: doc/BRIEF.md
# Checker Signature Capture and Dictionary Matcher

This block sits behind a bank of invariance checkers in a mixed-signal self-test path. Each checker raises a fail bit when its monitored invariant leaves its tolerance window. After a start strobe, the block records one fail bit per checker per cycle for a fixed run length. It arranges the recorded streams into one wide signature word.

Once recording ends, the block walks through a small on-chip dictionary of expected defect signatures, comparing one row per cycle. A row matches only when it equals the signature exactly, which is a Hamming distance of zero. The block reports three results: the lowest matching row, how many rows matched (the size of the ambiguity group), and a flag for the case where no row matched. Software loads the dictionary rows through a simple write port before a run starts. The results stay visible with a done flag until the next start.

Top module: `sig_match`

## Requirements
- R1: After reset, done_o, no_match_o, match_idx_o and match_cnt_o are all 0.
- R2: A high start_i clears done_o on the next edge. done_o rises on the (RUN_LEN+ROWS)-th rising edge after the edge that samples start_i, which is 48 with the default parameters, and not earlier.
- R3: fail_i[c] sampled on the (i+1)-th edge after start lands in signature bit c*RUN_LEN+i. Checker 0 therefore fills bits 31:0. A checker failing on every cycle yields all ones in its field, and a checker that always passes yields all zeros.
- R4: match_cnt_o equals the number of dictionary rows whose contents equal the captured signature.
- R5: When at least one row matches, match_idx_o is the lowest matching row number.
- R6: no_match_o is 1 exactly when no row matches. In that case match_idx_o and match_cnt_o are 0.
- R7: While done_o is high and start_i stays low, done_o and all result outputs hold their values.
- R8: A start_i pulse during a run abandons that run. The outcome then depends only on the samples after the new start.
- R9: Dictionary rows are 0 after reset. A write with wr_en_i stores wr_data_i into row wr_addr_i, and the latest write to a row is the one that counts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Run start strobe |
| fail_i | input | NUM_CHK | Per-checker fail bit, one sample per cycle |
| wr_en_i | input | 1 | Dictionary write enable |
| wr_addr_i | input | $clog2(ROWS) | Dictionary row to write |
| wr_data_i | input | NUM_CHK*RUN_LEN | Signature written into the row |
| done_o | output | 1 | Results valid; held until next start |
| match_idx_o | output | $clog2(ROWS) | Lowest matching row |
| match_cnt_o | output | $clog2(ROWS+1) | Number of matching rows |
| no_match_o | output | 1 | No row matched |

## Verification
The start strobe is sampled on edge E0. Fail samples are presented before edges E1 through E32, and each result is due on edge E48. The bench changes inputs only on falling edges and reads outputs on falling edges. It checks that done_o is still low just after E47 and that every result is correct just after E48. The hold check reads the outputs again many cycles later, and the restart check counts the 48 edges from the second strobe rather than the first.

// File: rtl/sig_match_pkg.sv
package sig_match_pkg;
   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_CAPT = 2'd1,
      PH_SCAN = 2'd2
   } phase_t;
endpackage

// File: rtl/sig_capture.sv
module sig_capture #(
   parameter int NUM_CHK = 6,
   parameter int RUN_LEN = 32
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       clear_i,
   input  logic                       shift_i,
   input  logic [NUM_CHK-1:0]         fail_i,
   output logic [NUM_CHK*RUN_LEN-1:0] sig_o
);
   if (NUM_CHK < 1) begin : g_bad_chk
      $error("sig_capture: NUM_CHK must be at least 1");
   end
   if (RUN_LEN < 2) begin : g_bad_len
      $error("sig_capture: RUN_LEN must be at least 2");
   end

   // one right-shifting lane per checker: the first sample ends in the lowest bit
   for (genvar c = 0; c < NUM_CHK; c++) begin : g_lane
      logic [RUN_LEN-1:0] lane_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            lane_q <= '0;
         end else if (clear_i) begin
            lane_q <= '0;
         end else if (shift_i) begin
            lane_q <= {fail_i[c], lane_q[RUN_LEN-1:1]};
         end
      end
      assign sig_o[c*RUN_LEN +: RUN_LEN] = lane_q;
   end

   // R3
   lane_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!shift_i && !clear_i) |=> $stable(sig_o));
endmodule

// File: rtl/sig_dict.sv
module sig_dict #(
   parameter int ROWS  = 16,
   parameter int SIG_W = 192
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    wr_en_i,
   input  logic [$clog2(ROWS)-1:0] wr_addr_i,
   input  logic [SIG_W-1:0]        wr_data_i,
   input  logic [$clog2(ROWS)-1:0] rd_addr_i,
   output logic [SIG_W-1:0]        rd_data_o
);
   localparam int ROW_W = $clog2(ROWS);

   if (ROWS < 2) begin : g_bad_rows
      $error("sig_dict: ROWS must be at least 2");
   end
   if ((1 << ROW_W) != ROWS) begin : g_bad_pow
      $error("sig_dict: ROWS must be a power of two");
   end

   logic [SIG_W-1:0] rows_q [ROWS];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int r = 0; r < ROWS; r++) begin
            rows_q[r] <= '0;
         end
      end else if (wr_en_i) begin
         rows_q[wr_addr_i] <= wr_data_i;
      end
   end

   assign rd_data_o = rows_q[rd_addr_i];

   // R9
   dict_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en_i |=> (rows_q[$past(wr_addr_i)] == $past(wr_data_i)));
endmodule

// File: rtl/sig_compare.sv
module sig_compare #(
   parameter int NUM_CHK = 6,
   parameter int RUN_LEN = 32
) (
   input  logic [NUM_CHK*RUN_LEN-1:0] sig_a_i,
   input  logic [NUM_CHK*RUN_LEN-1:0] sig_b_i,
   output logic                       hit_o
);
   logic [NUM_CHK-1:0] lane_eq;

   // per-checker equality, combined: zero distance needs every lane equal
   for (genvar c = 0; c < NUM_CHK; c++) begin : g_cmp
      assign lane_eq[c] = ~|(sig_a_i[c*RUN_LEN +: RUN_LEN] ^ sig_b_i[c*RUN_LEN +: RUN_LEN]);
   end

   assign hit_o = &lane_eq;
endmodule

// File: rtl/sig_sequencer.sv
module sig_sequencer
   import sig_match_pkg::*;
#(
   parameter int RUN_LEN = 32,
   parameter int ROWS    = 16
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      start_i,
   input  logic                      hit_i,
   output logic                      clear_o,
   output logic                      shift_o,
   output logic [$clog2(ROWS)-1:0]   row_o,
   output logic                      done_o,
   output logic [$clog2(ROWS)-1:0]   match_idx_o,
   output logic [$clog2(ROWS+1)-1:0] match_cnt_o,
   output logic                      no_match_o
);
   localparam int ROW_W  = $clog2(ROWS);
   localparam int CNT_W  = $clog2(ROWS + 1);
   localparam int SAMP_W = $clog2(RUN_LEN);

   if (RUN_LEN < 2) begin : g_bad_len
      $error("sig_sequencer: RUN_LEN must be at least 2");
   end
   if (ROWS < 2) begin : g_bad_rows
      $error("sig_sequencer: ROWS must be at least 2");
   end

   phase_t             phase_q;
   logic [SAMP_W-1:0]  samp_q;
   logic [ROW_W-1:0]   row_q;
   logic [CNT_W-1:0]   acc_cnt_q;
   logic [ROW_W-1:0]   acc_idx_q;
   logic               acc_found_q;

   logic [CNT_W-1:0]   nxt_cnt;
   logic [ROW_W-1:0]   nxt_idx;
   logic               nxt_found;
   logic               last_samp;
   logic               last_row;

   assign last_samp = (samp_q == SAMP_W'(RUN_LEN - 1));
   assign last_row  = (row_q == ROW_W'(ROWS - 1));

   always_comb begin
      nxt_cnt   = acc_cnt_q;
      nxt_idx   = acc_idx_q;
      nxt_found = acc_found_q;
      if (hit_i) begin
         nxt_cnt = acc_cnt_q + CNT_W'(1);
         if (!acc_found_q) begin
            nxt_idx   = row_q;
            nxt_found = 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q     <= PH_IDLE;
         samp_q      <= '0;
         row_q       <= '0;
         acc_cnt_q   <= '0;
         acc_idx_q   <= '0;
         acc_found_q <= 1'b0;
         done_o      <= 1'b0;
         match_idx_o <= '0;
         match_cnt_o <= '0;
         no_match_o  <= 1'b0;
      end else if (start_i) begin
         phase_q     <= PH_CAPT;
         samp_q      <= '0;
         row_q       <= '0;
         acc_cnt_q   <= '0;
         acc_idx_q   <= '0;
         acc_found_q <= 1'b0;
         done_o      <= 1'b0;
         match_idx_o <= '0;
         match_cnt_o <= '0;
         no_match_o  <= 1'b0;
      end else begin
         unique case (phase_q)
            PH_CAPT: begin
               samp_q <= samp_q + SAMP_W'(1);
               if (last_samp) begin
                  phase_q <= PH_SCAN;
                  row_q   <= '0;
               end
            end
            PH_SCAN: begin
               acc_cnt_q   <= nxt_cnt;
               acc_idx_q   <= nxt_idx;
               acc_found_q <= nxt_found;
               if (last_row) begin
                  phase_q     <= PH_IDLE;
                  done_o      <= 1'b1;
                  match_cnt_o <= nxt_cnt;
                  match_idx_o <= nxt_found ? nxt_idx : '0;
                  no_match_o  <= !nxt_found;
               end else begin
                  row_q <= row_q + ROW_W'(1);
               end
            end
            default: begin
               phase_q <= PH_IDLE;
            end
         endcase
      end
   end

   assign clear_o = start_i;
   assign shift_o = (phase_q == PH_CAPT) && !start_i;
   assign row_o   = row_q;

   // R2
   start_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |=> !done_o);
   // R2
   done_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done_o) |-> ($past(phase_q) == PH_SCAN));
   // R7
   done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && !start_i) |=> (done_o && $stable(match_cnt_o)
                                && $stable(match_idx_o) && $stable(no_match_o)));
   // R6
   nomatch_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (no_match_o == (match_cnt_o == '0)));
   // R6
   nomatch_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && no_match_o) |-> (match_idx_o == '0));
   // R4
   cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      match_cnt_o <= CNT_W'(ROWS));
endmodule

// File: rtl/sig_match.sv
module sig_match #(
   parameter int NUM_CHK = 6,
   parameter int RUN_LEN = 32,
   parameter int ROWS    = 16
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       start_i,
   input  logic [NUM_CHK-1:0]         fail_i,
   input  logic                       wr_en_i,
   input  logic [$clog2(ROWS)-1:0]    wr_addr_i,
   input  logic [NUM_CHK*RUN_LEN-1:0] wr_data_i,
   output logic                       done_o,
   output logic [$clog2(ROWS)-1:0]    match_idx_o,
   output logic [$clog2(ROWS+1)-1:0]  match_cnt_o,
   output logic                       no_match_o
);
   localparam int SIG_W = NUM_CHK * RUN_LEN;
   localparam int ROW_W = $clog2(ROWS);

   logic             clear;
   logic             shift;
   logic             hit;
   logic [ROW_W-1:0] row;
   logic [SIG_W-1:0] sig;
   logic [SIG_W-1:0] row_data;

   sig_capture #(.NUM_CHK(NUM_CHK), .RUN_LEN(RUN_LEN)) u_capture (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear_i (clear),
      .shift_i (shift),
      .fail_i  (fail_i),
      .sig_o   (sig)
   );

   sig_dict #(.ROWS(ROWS), .SIG_W(SIG_W)) u_dict (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en_i   (wr_en_i),
      .wr_addr_i (wr_addr_i),
      .wr_data_i (wr_data_i),
      .rd_addr_i (row),
      .rd_data_o (row_data)
   );

   sig_compare #(.NUM_CHK(NUM_CHK), .RUN_LEN(RUN_LEN)) u_compare (
      .sig_a_i (sig),
      .sig_b_i (row_data),
      .hit_o   (hit)
   );

   sig_sequencer #(.RUN_LEN(RUN_LEN), .ROWS(ROWS)) u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .start_i     (start_i),
      .hit_i       (hit),
      .clear_o     (clear),
      .shift_o     (shift),
      .row_o       (row),
      .done_o      (done_o),
      .match_idx_o (match_idx_o),
      .match_cnt_o (match_cnt_o),
      .no_match_o  (no_match_o)
   );
endmodule

// File: tb/sig_match_tb.sv
module sig_match_tb;
   localparam int NUM_CHK = 6;
   localparam int RUN_LEN = 32;
   localparam int ROWS    = 16;
   localparam int SIG_W   = NUM_CHK * RUN_LEN;
   localparam int ROW_W   = $clog2(ROWS);
   localparam int CNT_W   = $clog2(ROWS + 1);

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic               start_i = 1'b0;
   logic [NUM_CHK-1:0] fail_i = '0;
   logic               wr_en_i = 1'b0;
   logic [ROW_W-1:0]   wr_addr_i = '0;
   logic [SIG_W-1:0]   wr_data_i = '0;
   logic               done_o;
   logic [ROW_W-1:0]   match_idx_o;
   logic [CNT_W-1:0]   match_cnt_o;
   logic               no_match_o;

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   logic [SIG_W-1:0] model [ROWS];

   always #10 clk = ~clk;

   sig_match #(.NUM_CHK(NUM_CHK), .RUN_LEN(RUN_LEN), .ROWS(ROWS)) u_dut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .fail_i(fail_i),
      .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
      .done_o(done_o), .match_idx_o(match_idx_o), .match_cnt_o(match_cnt_o),
      .no_match_o(no_match_o));

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic logic [SIG_W-1:0] mk_sig(input int seed);
      logic [SIG_W-1:0] s;
      for (int c = 0; c < NUM_CHK; c++) begin
         s[c*RUN_LEN +: RUN_LEN] = 32'(seed * 32'h9E3779B1 + (c + 1) * 32'h7F4A7C15)
                                  ^ 32'(c * 32'h01010101);
      end
      return s;
   endfunction

   task automatic wr_row(input int r, input logic [SIG_W-1:0] d);
      @(negedge clk);
      wr_en_i   = 1'b1;
      wr_addr_i = ROW_W'(r);
      wr_data_i = d;
      model[r]  = d;
      @(negedge clk);
      wr_en_i   = 1'b0;
   endtask

   task automatic feed(input logic [SIG_W-1:0] s, input int nsamp);
      @(negedge clk);
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      for (int i = 0; i < nsamp; i++) begin
         for (int c = 0; c < NUM_CHK; c++) fail_i[c] = s[c*RUN_LEN + i];
         @(negedge clk);
      end
      fail_i = '0;
   endtask

   task automatic run_chk(input string tag, input logic [SIG_W-1:0] s);
      int ecnt;
      int eidx;
      ecnt = 0;
      eidx = 0;
      for (int r = ROWS - 1; r >= 0; r--) begin
         if (model[r] == s) begin
            ecnt++;
            eidx = r;
         end
      end
      feed(s, RUN_LEN);
      // now just past edge E32; results due on E48
      repeat (ROWS - 1) @(negedge clk);
      chk({tag, " R2 done low before E48"}, int'(done_o), 0);
      @(negedge clk);
      chk({tag, " R2 done at E48"}, int'(done_o), 1);
      chk({tag, " R4 count"}, int'(match_cnt_o), ecnt);
      chk({tag, " R5 index"}, int'(match_idx_o), eidx);
      chk({tag, " R6 no_match"}, int'(no_match_o), (ecnt == 0) ? 1 : 0);
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         errors++;
         $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      for (int r = 0; r < ROWS; r++) model[r] = '0;
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 done", int'(done_o), 0);
      chk("R1 no_match", int'(no_match_o), 0);
      chk("R1 idx", int'(match_idx_o), 0);
      chk("R1 cnt", int'(match_cnt_o), 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R9: rows are zero after reset, so an all-pass run matches every row
      run_chk("R9 zero rows", '0);
      // R6: all-fail signature matches nothing yet
      run_chk("R6 ones nomatch", '1);

      // load dictionary with duplicates forming ambiguity groups
      for (int r = 0; r < ROWS; r++) wr_row(r, mk_sig(r + 100));
      wr_row(9, mk_sig(103));
      wr_row(6, mk_sig(105));
      wr_row(12, mk_sig(105));
      wr_row(14, '0);
      wr_row(15, '1);

      // R4 R5: sweep every row
      for (int r = 0; r < ROWS; r++) run_chk("R4 R5 row sweep", model[r]);
      // R6 absent signature
      run_chk("R6 absent", mk_sig(7777));
      // R3 permanent violation on all checkers -> all ones row 15
      run_chk("R3 all fail", '1);
      run_chk("R3 all pass", '0);

      // R3 bit placement: single set bit per checker at several samples
      for (int c = 0; c < NUM_CHK; c++) begin
         for (int k = 0; k < 3; k++) begin
            int i;
            logic [SIG_W-1:0] one;
            i = (k == 0) ? 0 : ((k == 1) ? 13 : RUN_LEN - 1);
            one = '0;
            one[c*RUN_LEN + i] = 1'b1;
            wr_row(0, one);
            run_chk("R3 placement", one);
            chk("R3 placement idx", int'(match_idx_o), 0);
         end
      end
      // R3: a sample in the neighbouring lane must not match
      begin
         logic [SIG_W-1:0] a;
         logic [SIG_W-1:0] b;
         a = '0; a[RUN_LEN + 4] = 1'b1;
         b = '0; b[4] = 1'b1;
         wr_row(0, a);
         run_chk("R3 lane swap", b);
         chk("R3 lane swap nomatch", int'(no_match_o), 1);
      end

      // R9 last write wins
      wr_row(2, mk_sig(1));
      wr_row(2, mk_sig(2));
      run_chk("R9 rewrite new", mk_sig(2));
      chk("R9 rewrite idx", int'(match_idx_o), 2);
      run_chk("R9 rewrite old", mk_sig(1));
      chk("R9 old gone", int'(no_match_o), 1);

      // R7 hold
      run_chk("R7 base", model[5]);
      repeat (25) @(negedge clk);
      chk("R7 done held", int'(done_o), 1);
      chk("R7 cnt held", int'(match_cnt_o), 3);
      chk("R7 idx held", int'(match_idx_o), 5);
      chk("R7 nomatch held", int'(no_match_o), 0);

      // R8 restart mid-run
      feed('1, 10);
      chk("R8 done cleared", int'(done_o), 0);
      run_chk("R8 restart", model[7]);
      chk("R8 restart idx", int'(match_idx_o), 7);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule